// File: doc/BRIEF.md
# Multi-Gate Hardware Semaphore

This block holds an array of semaphore gates that several bus masters share to take turns at common resources. Each gate reads as zero while free and as the owner's master ID plus one while held. A master claims a gate by writing its encoded ID to it. It then reads the gate back: if the value matches what it wrote, it owns the gate. The owner gives the gate back by writing zero. A write from any other master, or one that carries a value that does not match the writer, leaves the gate unchanged.

A reset register next to the gates lets software force gates free when an owner has died. Forcing takes a keyed pair of writes. The first write arms the sequencer. The second write, which must come right after the first, fires it and names either one gate or all of them. A status output shows whether the sequencer is armed. It also shows the master and the target field of the most recent reset-register write.

All writes arrive on one plain write port with a select bit that picks the gate array or the reset register. The port takes one write per clock and never stalls, so it has no ready signal. Gate reads are combinational through a separate index.

Top module: `sema_bank`

## Requirements
- R1: After reset every gate reads 0, the sequencer is not armed, and the last-master and last-target status outputs read 0.
- R2: A gate write (wr_sel=0) whose value in wr_data[7:0] equals wr_mid+1, aimed at a free gate, makes that gate read wr_mid+1 from the next cycle.
- R3: A lock write to a gate held by a different master leaves the owner value unchanged.
- R4: A gate write whose nonzero value differs from the writer's wr_mid+1 has no effect on the gate.
- R5: The owner writing 0 frees the gate. A 0 written by any master that is not the owner is ignored.
- R6: Gate writes with wr_idx at or above GATES (16) change no gate, and reading such an index returns 0.
- R7: A reset-register write (wr_sel=1) with key 0xE2 in wr_data[7:0] arms the sequencer when it is idle, and the armed output is high from the next cycle. The next write, if it is a reset-register write with key 0x1D, clears the gate named in wr_data[15:8] and returns the sequencer to idle.
- R8: If the target field of the firing write is at or above RST_ALL (64), every gate is cleared in that same cycle.
- R9: Any of the following returns the sequencer to idle and clears no gate: a wrong key, 0xE2 written while armed, or a gate write while armed. A firing target in the range GATES to RST_ALL-1 also clears no gate.
- R10: Every reset-register write loads its wr_mid into the last-master status output and its wr_data[15:8] into the last-target status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | 0 = gate array, 1 = reset register |
| wr_idx | input | 8 | Gate index for gate writes |
| wr_mid | input | 3 | ID of the writing master |
| wr_data | input | 16 | [7:0] gate value or key, [15:8] reset target |
| rd_idx | input | 8 | Gate index to read |
| rd_val | output | 8 | Owner value of the indexed gate, 0 if free or out of range |
| rst_armed | output | 1 | Sequencer holds the first key and waits for the second |
| rst_last_mid | output | 3 | Master of the last reset-register write |
| rst_last_tgt | output | 8 | Target field of the last reset-register write |

## Verification
The lock rule is tested in turn with a matching value on a free gate, a matching value on a held gate, a mismatched nonzero value, and zero from the owner and from a stranger. Together these separate the lock check, the ownership check and the release check. The reset sequencer is driven with a clean key pair, a broken pair of each kind, and target values at, below and between the single-gate and all-gates limits. This separates arming, aborting and the target decode. A long random mix of gate and reset writes is then compared every clock against a behavioural model, which catches ordering effects that the directed cases miss.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam logic [7:0] KEY_ARM  = 8'hE2;
  localparam logic [7:0] KEY_FIRE = 8'h1D;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sema_gate.sv
module sema_gate #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [VW-1:0] wr_val,
  input  logic [VW-1:0] wr_enc,
  input  logic          clr,
  output logic [VW-1:0] owner
);
  logic is_free, is_mine, take, give;

  assign is_free = (owner == '0);
  assign is_mine = (owner == wr_enc);
  assign take    = wr && is_free && (wr_val == wr_enc) && (wr_val != '0);
  assign give    = wr && !is_free && is_mine && (wr_val == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      owner <= '0;
    else if (clr)    owner <= '0;
    else if (take)   owner <= wr_val;
    else if (give)   owner <= '0;
  end

  // R3: foreign write on a held gate keeps the owner
  a_r3_held_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && owner != '0 && owner != wr_enc) |=> $stable(owner));

  // R4: mismatched nonzero value never locks
  a_r4_bad_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && owner == '0 && wr_val != wr_enc) |=> (owner == '0));

  // R2: a gate only ever takes the encoded ID of its writer
  a_r2_lock_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && owner == '0 && wr_val == wr_enc && wr_val != '0) |=> (owner == $past(wr_enc)));

  // R5: owner zero write frees the gate
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && owner != '0 && owner == wr_enc && wr_val == '0) |=> (owner == '0));
endmodule

// File: rtl/sema_rst_seq.sv
module sema_rst_seq #(
  parameter int GATES   = 16,
  parameter int RST_ALL = 64,
  parameter int ADDR_W  = 8,
  parameter int MID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rw_en,
  input  logic              gw_en,
  input  logic [7:0]        key,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [MID_W-1:0]  mid,
  output logic              armed,
  output logic [GATES-1:0]  clr_vec,
  output logic [MID_W-1:0]  last_mid,
  output logic [ADDR_W-1:0] last_tgt
);
  import sema_pkg::*;

  localparam logic [ADDR_W-1:0] ALL_A = ADDR_W'(RST_ALL);

  seq_state_e state_q;
  logic       fire, hit_all;

  assign armed   = (state_q == SEQ_ARMED);
  assign fire    = rw_en && armed && (key == KEY_FIRE);
  assign hit_all = (tgt >= ALL_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      last_mid <= '0;
      last_tgt <= '0;
    end else if (rw_en) begin
      last_mid <= mid;
      last_tgt <= tgt;
      if (state_q == SEQ_IDLE && key == KEY_ARM) state_q <= SEQ_ARMED;
      else                                        state_q <= SEQ_IDLE;
    end else if (gw_en) begin
      state_q <= SEQ_IDLE;
    end
  end

  for (genvar g = 0; g < GATES; g++) begin : g_clr
    assign clr_vec[g] = fire && (hit_all || tgt == ADDR_W'(g));
  end

  // R7: arming key from idle arms the sequencer
  a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && rw_en && key == KEY_ARM) |=> armed);

  // R9: an intervening gate write aborts
  a_r9_gate_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && gw_en && !rw_en) |=> !armed);

  // R9: no clear pulse without an armed sequencer
  a_r9_no_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |-> (clr_vec == '0));

  // R10: status captures each reset-register write
  a_r10_status: assert property (@(posedge clk) disable iff (!rst_n)
    rw_en |=> (last_mid == $past(mid) && last_tgt == $past(tgt)));
endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int GATES   = 16,
  parameter int MASTERS = 8,
  parameter int RST_ALL = 64,
  parameter int ADDR_W  = 8,
  parameter int MID_W   = $clog2(MASTERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [MID_W-1:0]  wr_mid,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_idx,
  output logic [7:0]        rd_val,
  output logic              rst_armed,
  output logic [MID_W-1:0]  rst_last_mid,
  output logic [ADDR_W-1:0] rst_last_tgt
);
  localparam int VW = 8;
  localparam logic [ADDR_W-1:0] GATES_A = ADDR_W'(GATES);
  localparam logic [ADDR_W-1:0] ALL_A   = ADDR_W'(RST_ALL);

  logic [GATES-1:0][VW-1:0] own_q;
  logic [GATES-1:0]         clr_vec;
  logic [VW-1:0]            enc;
  logic                     gw_en, rw_en;

  assign enc   = VW'(wr_mid) + VW'(1);
  assign gw_en = wr_en && !wr_sel;
  assign rw_en = wr_en && wr_sel;

  for (genvar g = 0; g < GATES; g++) begin : g_gate
    sema_gate #(.VW(VW)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (gw_en && wr_idx == ADDR_W'(g)),
      .wr_val(wr_data[VW-1:0]),
      .wr_enc(enc),
      .clr   (clr_vec[g]),
      .owner (own_q[g])
    );
  end

  sema_rst_seq #(
    .GATES(GATES), .RST_ALL(RST_ALL), .ADDR_W(ADDR_W), .MID_W(MID_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rw_en   (rw_en),
    .gw_en   (gw_en),
    .key     (wr_data[7:0]),
    .tgt     (wr_data[8+ADDR_W-1:8]),
    .mid     (wr_mid),
    .armed   (rst_armed),
    .clr_vec (clr_vec),
    .last_mid(rst_last_mid),
    .last_tgt(rst_last_tgt)
  );

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < GATES; g++)
      if (rd_idx == ADDR_W'(g)) rd_val = own_q[g];
  end

  // R6: writes beyond the gate count change nothing
  a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_en && wr_idx >= GATES_A) |=> $stable(own_q));

  // R8: firing with an all-gates target empties the array
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_en && rst_armed && wr_data[7:0] == sema_pkg::KEY_FIRE && wr_data[8+ADDR_W-1:8] >= ALL_A)
    |=> (own_q == '0));

  // R9: a dead-zone target clears nothing
  a_r9_dead_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_en && wr_data[8+ADDR_W-1:8] >= GATES_A && wr_data[8+ADDR_W-1:8] < ALL_A) |=> $stable(own_q));
endmodule

// File: tb/sema_bank_tb.sv
`timescale 1ns/1ps
module sema_bank_tb;
  localparam int GATES = 16;
  localparam int RST_ALL = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_idx = '0;
  logic [2:0] wr_mid = '0;
  logic [15:0] wr_data = '0;
  logic [7:0] rd_idx = '0;
  logic [7:0] rd_val;
  logic       rst_armed;
  logic [2:0] rst_last_mid;
  logic [7:0] rst_last_tgt;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_gate[GATES];
  bit m_armed;
  int m_lastm, m_lastg;

  always #4 clk = ~clk;

  sema_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_mid(wr_mid), .wr_data(wr_data), .rd_idx(rd_idx), .rd_val(rd_val),
    .rst_armed(rst_armed), .rst_last_mid(rst_last_mid), .rst_last_tgt(rst_last_tgt)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_gate[i]) m_gate[i] = 0;
      m_armed = 0; m_lastm = 0; m_lastg = 0;
    end else if (wr_en) begin
      if (!wr_sel) begin
        int enc, v;
        m_armed = 0;
        enc = int'(wr_mid) + 1;
        v = int'(wr_data[7:0]);
        if (wr_idx < GATES) begin
          if (m_gate[wr_idx] == 0 && v == enc) m_gate[wr_idx] = v;
          else if (m_gate[wr_idx] == enc && v == 0) m_gate[wr_idx] = 0;
        end
      end else begin
        int k, t;
        k = int'(wr_data[7:0]);
        t = int'(wr_data[15:8]);
        m_lastm = int'(wr_mid);
        m_lastg = t;
        if (m_armed && k == 8'h1D) begin
          if (t >= RST_ALL) foreach (m_gate[i]) m_gate[i] = 0;
          else if (t < GATES) m_gate[t] = 0;
        end
        m_armed = !m_armed && (k == 8'hE2);
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      for (int g = 0; g < GATES + 2; g++) begin
        rd_idx = 8'(g);
        #0.1;
        chk(int'(rd_val) == ((g < GATES) ? m_gate[g] : 0), "R2 model gate", int'(rd_val),
            (g < GATES) ? m_gate[g] : 0);
      end
      chk(rst_armed == m_armed, "R7 model armed", int'(rst_armed), int'(m_armed));
      chk(int'(rst_last_mid) == m_lastm, "R10 model master", int'(rst_last_mid), m_lastm);
      chk(int'(rst_last_tgt) == m_lastg, "R10 model target", int'(rst_last_tgt), m_lastg);
    end
  end

  task automatic wr(bit sel, int idx, int mid, int data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_idx = 8'(idx); wr_mid = 3'(mid); wr_data = 16'(data);
    @(posedge clk);
    #1;
    wr_en = 0;
  endtask

  task automatic gw(int idx, int mid, int val); wr(0, idx, mid, val); endtask
  task automatic rw(int mid, int key, int tgt); wr(1, 0, mid, (tgt << 8) | key); endtask

  task automatic peek(int idx, int exp, string tag);
    rd_idx = 8'(idx);
    #0.1;
    chk(int'(rd_val) == exp, tag, int'(rd_val), exp);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #0.5;
    for (int g = 0; g < GATES; g++) peek(g, 0, "R1 reset gate");
    chk(rst_armed == 0, "R1 reset armed", int'(rst_armed), 0);
    chk(rst_last_mid == 0 && rst_last_tgt == 0, "R1 reset status", int'(rst_last_tgt), 0);

    gw(0, 0, 1);  peek(0, 1, "R2 lock m0");
    gw(0, 2, 3);  peek(0, 1, "R3 held by m0");
    gw(1, 1, 5);  peek(1, 0, "R4 wrong value");
    gw(1, 1, 2);  peek(1, 2, "R2 lock m1");
    gw(1, 0, 0);  peek(1, 2, "R5 stranger zero");
    gw(1, 1, 0);  peek(1, 0, "R5 owner release");
    gw(20, 3, 4); peek(20, 0, "R6 out of range");
    gw(16, 3, 4); peek(16, 0, "R6 first invalid");
    gw(15, 7, 8); peek(15, 8, "R2 top gate max id");

    rw(4, 8'hE2, 0);
    chk(rst_armed == 1, "R7 armed", int'(rst_armed), 1);
    rw(4, 8'h1D, 0);
    peek(0, 0, "R7 single clear");
    peek(15, 8, "R7 other kept");
    chk(rst_armed == 0, "R7 back idle", int'(rst_armed), 0);
    chk(rst_last_mid == 4, "R10 last master", int'(rst_last_mid), 4);

    gw(3, 5, 6);
    rw(1, 8'hE2, 0); gw(9, 1, 9); rw(1, 8'h1D, 3);
    peek(3, 6, "R9 gate write abort");
    rw(1, 8'hE2, 0); rw(1, 8'h55, 3);
    chk(rst_armed == 0, "R9 wrong key idle", int'(rst_armed), 1'b0);
    rw(1, 8'h1D, 3); peek(3, 6, "R9 wrong key no clear");
    rw(1, 8'hE2, 0); rw(1, 8'hE2, 3); rw(1, 8'h1D, 3);
    peek(3, 6, "R9 double arm");
    rw(2, 8'hE2, 0); rw(2, 8'h1D, 40);
    peek(3, 6, "R9 dead target");
    chk(rst_last_tgt == 40, "R10 last target", int'(rst_last_tgt), 40);

    rw(6, 8'hE2, 0); rw(6, 8'h1D, RST_ALL);
    peek(3, 0, "R8 all clear g3"); peek(15, 0, "R8 all clear g15");
    gw(7, 2, 3); rw(0, 8'hE2, 0); rw(0, 8'h1D, 255);
    peek(7, 0, "R8 all clear 255");

    for (int n = 0; n < 3000; n++) begin
      int r, m;
      r = $urandom_range(0, 9);
      m = $urandom_range(0, 7);
      if (r < 7) begin
        int v;
        case ($urandom_range(0, 3))
          0, 1: v = m + 1;
          2: v = 0;
          default: v = $urandom_range(0, 255);
        endcase
        gw($urandom_range(0, GATES + 1), m, v);
      end else begin
        int k, t;
        case ($urandom_range(0, 2))
          0: k = 8'hE2;
          1: k = 8'h1D;
          default: k = $urandom_range(0, 255);
        endcase
        case ($urandom_range(0, 3))
          0: t = RST_ALL + $urandom_range(0, 10);
          1: t = $urandom_range(GATES, RST_ALL - 1);
          default: t = $urandom_range(0, GATES - 1);
        endcase
        rw(m, k, t);
      end
    end

    @(negedge clk); #3.9;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule